// File: doc/BRIEF.md
# Bit-Reversed Station Address Loader

This block fetches a 48-bit station address from a small byte-wide PROM and decides whether the PROM contents can be trusted. It runs by itself when reset is released, and again whenever `start_i` is pulsed. It issues one read at a time: a single-cycle strobe together with a byte address. The PROM entries lie on a sparse stride, so entry j sits at byte address j multiplied by 2^STRIDE_LOG2. Read data comes back a fixed number of cycles (`RD_LAT`) after the strobe.

Each returned byte is stored in the PROM with its bits in reverse order, so the block flips it back. The first six corrected bytes make up the station address. All eight corrected bytes are folded together with XOR, and the contents count as good only when that fold equals 0xFF.

The published address register keeps its old value for the whole fetch and is replaced in a single step at completion. At that point a done flag and a valid flag are raised. Both flags hold until the next reset or restart.

Top module: `station_addr_loader`

## Requirements
- R1: Reads are single-cycle strobes on `rom_rd_o`. The strobe for entry j carries `rom_addr_o` = j*16, with the low four bits zero. Entries are read in the order 0,1,...,7. After the first strobe of a run, consecutive strobes are exactly RD_LAT+1 cycles apart.
- R2: The byte for a strobe issued in cycle c is taken from `rom_data_i` in cycle c+RD_LAT. The value on `rom_data_i` in any other cycle has no effect on the result.
- R3: Every captured byte is bit-reversed: PROM bit i becomes bit 7-i.
- R4: The corrected entries 0..5 form the station address with entry 0 in bits 47:40, down to entry 5 in bits 7:0.
- R5: `valid_o` is 1 exactly when the XOR of all eight corrected entries equals 8'hFF. Entries 6 and 7 affect only this check and never the address.
- R6: `done_o` rises in the cycle after entry 7 is captured, which is 8*(RD_LAT+1) cycles after a restart is sampled. It then stays at 1 with no further strobes until reset or restart. `valid_o` is 0 whenever `done_o` is 0.
- R7: `station_addr_o` keeps its previous value while a fetch runs. It changes only in the cycle where `done_o` rises, and it is loaded then even if the check fails.
- R8: A `start_i` pulse drops `done_o` and `valid_o` in the next cycle and begins a new fetch from entry 0 with a fresh check. When the pulse falls in the capture cycle of entry 7, the restart wins: `done_o` does not rise and the address is not replaced.
- R9: While `rst_n` is low, `done_o`, `valid_o` and `station_addr_o` are 0. The first strobe, for entry 0, comes in the first cycle after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| start_i | input | 1 | Restart pulse |
| rom_rd_o | output | 1 | PROM read strobe |
| rom_addr_o | output | 7 | PROM byte address |
| rom_data_i | input | 8 | PROM read data, RD_LAT cycles after the strobe |
| station_addr_o | output | 48 | Published station address |
| done_o | output | 1 | Fetch finished |
| valid_o | output | 1 | Checksum matched |

## Verification
The two functions that can land in the same cycle are the capture of the final entry and a restart request. The bench times a `start_i` pulse to hit exactly the capture cycle of entry 7, counting that cycle from the previous restart. It then judges that `done_o` stays low, that the published address keeps its old value, and that the next full fetch completes on schedule with the new contents. Mid-run restarts and resets are mixed in as well, and random PROM images, forced half the time to pass the check, cover the address and checksum paths.

// File: rtl/salp_pkg.sv
package salp_pkg;
  typedef enum logic [1:0] {
    ST_ISSUE = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DONE  = 2'd2
  } seq_state_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/salp_bit_rev.sv
module salp_bit_rev #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_swap
    assign q_o[b] = d_i[W-1-b];
  end
endmodule

// File: rtl/salp_read_seq.sv
module salp_read_seq
  import salp_pkg::*;
#(
  parameter int unsigned ENTRIES     = 8,
  parameter int unsigned STRIDE_LOG2 = 4,
  parameter int unsigned RD_LAT      = 2,
  localparam int unsigned IW = $clog2(ENTRIES),
  localparam int unsigned AW = IW + STRIDE_LOG2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          rd_o,
  output logic [AW-1:0] addr_o,
  output logic          cap_o,
  output logic [IW-1:0] cap_idx_o,
  output logic          last_o
);
  localparam int unsigned CW = $clog2(RD_LAT + 1);

  seq_state_e    state_q, state_n;
  logic [IW-1:0] idx_q, idx_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          capture;
  logic          is_last;

  assign capture = (state_q == ST_WAIT) && (cnt_q == CW'(RD_LAT));
  assign is_last = (idx_q == IW'(ENTRIES - 1));

  // next-state logic
  always_comb begin
    state_n = state_q;
    idx_n   = idx_q;
    cnt_n   = cnt_q;
    if (start_i) begin
      state_n = ST_ISSUE;
      idx_n   = '0;
      cnt_n   = '0;
    end else begin
      unique case (state_q)
        ST_ISSUE: begin
          state_n = ST_WAIT;
          cnt_n   = CW'(1);
        end
        ST_WAIT: begin
          if (capture) begin
            cnt_n = '0;
            if (is_last) begin
              state_n = ST_DONE;
            end else begin
              state_n = ST_ISSUE;
              idx_n   = idx_q + IW'(1);
            end
          end else begin
            cnt_n = cnt_q + CW'(1);
          end
        end
        ST_DONE: state_n = ST_DONE;
        default: state_n = ST_ISSUE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ISSUE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      cnt_q   <= cnt_n;
    end
  end

  assign rd_o      = (state_q == ST_ISSUE);
  assign addr_o    = {idx_q, {STRIDE_LOG2{1'b0}}};
  assign cap_o     = capture && !start_i;
  assign cap_idx_o = idx_q;
  assign last_o    = is_last;
endmodule

// File: rtl/salp_addr_accum.sv
module salp_addr_accum
  import salp_pkg::*;
#(
  parameter int unsigned ENTRIES     = 8,
  parameter int unsigned ADDR_BYTES  = 6,
  parameter logic [7:0]  CHECK_VALUE = 8'hFF,
  localparam int unsigned IW = $clog2(ENTRIES),
  localparam int unsigned DW = ADDR_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cap_i,
  input  logic [IW-1:0]     idx_i,
  input  logic              last_i,
  input  logic [BYTE_W-1:0] byte_i,
  output logic [DW-1:0]     addr_o,
  output logic              done_o,
  output logic              valid_o
);
  logic [BYTE_W-1:0] shadow_q [ADDR_BYTES];
  logic [BYTE_W-1:0] shadow_n [ADDR_BYTES];
  logic [DW-1:0]     packed_n;
  logic [BYTE_W-1:0] fold_q, fold_n;
  logic              fold_en;
  logic              commit_en;
  logic [DW-1:0]     addr_q;
  logic              done_q, done_n;
  logic              valid_q, valid_n;
  logic              flag_en;

  // per-byte shadow staging, entry 0 lands in the top byte
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_shadow
    logic wr_en;
    assign wr_en       = cap_i && (idx_i == IW'(k));
    assign shadow_n[k] = wr_en ? byte_i : shadow_q[k];
    assign packed_n[DW-1-BYTE_W*k -: BYTE_W] = shadow_n[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        shadow_q[k] <= '0;
      end else if (wr_en) begin
        shadow_q[k] <= byte_i;
      end
    end
  end

  // checksum fold
  assign fold_en = start_i || cap_i;
  assign fold_n  = start_i ? '0 : (fold_q ^ byte_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fold_q <= '0;
    end else if (fold_en) begin
      fold_q <= fold_n;
    end
  end

  // completion flags
  assign commit_en = cap_i && last_i;
  assign flag_en   = start_i || commit_en;

  always_comb begin
    done_n  = done_q;
    valid_n = valid_q;
    if (start_i) begin
      done_n  = 1'b0;
      valid_n = 1'b0;
    end else if (commit_en) begin
      done_n  = 1'b1;
      valid_n = (fold_n == CHECK_VALUE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      valid_q <= 1'b0;
    end else if (flag_en) begin
      done_q  <= done_n;
      valid_q <= valid_n;
    end
  end

  // published address, replaced in one step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (commit_en) begin
      addr_q <= packed_n;
    end
  end

  assign addr_o  = addr_q;
  assign done_o  = done_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/station_addr_loader.sv
module station_addr_loader
  import salp_pkg::*;
#(
  parameter int unsigned ENTRIES     = 8,
  parameter int unsigned ADDR_BYTES  = 6,
  parameter int unsigned STRIDE_LOG2 = 4,
  parameter int unsigned RD_LAT      = 2,
  parameter logic [7:0]  CHECK_VALUE = 8'hFF,
  localparam int unsigned IW = $clog2(ENTRIES),
  localparam int unsigned AW = IW + STRIDE_LOG2,
  localparam int unsigned DW = ADDR_BYTES * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  output logic              rom_rd_o,
  output logic [AW-1:0]     rom_addr_o,
  input  logic [BYTE_W-1:0] rom_data_i,
  output logic [DW-1:0]     station_addr_o,
  output logic              done_o,
  output logic              valid_o
);
  logic              cap;
  logic [IW-1:0]     cap_idx;
  logic              cap_last;
  logic [BYTE_W-1:0] fixed_byte;

  salp_read_seq #(
    .ENTRIES    (ENTRIES),
    .STRIDE_LOG2(STRIDE_LOG2),
    .RD_LAT     (RD_LAT)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .rd_o     (rom_rd_o),
    .addr_o   (rom_addr_o),
    .cap_o    (cap),
    .cap_idx_o(cap_idx),
    .last_o   (cap_last)
  );

  salp_bit_rev #(
    .W(BYTE_W)
  ) u_rev (
    .d_i(rom_data_i),
    .q_o(fixed_byte)
  );

  salp_addr_accum #(
    .ENTRIES    (ENTRIES),
    .ADDR_BYTES (ADDR_BYTES),
    .CHECK_VALUE(CHECK_VALUE)
  ) u_acc (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(start_i),
    .cap_i  (cap),
    .idx_i  (cap_idx),
    .last_i (cap_last),
    .byte_i (fixed_byte),
    .addr_o (station_addr_o),
    .done_o (done_o),
    .valid_o(valid_o)
  );
endmodule

// File: rtl/salp_checker.sv
module salp_checker #(
  parameter int unsigned ENTRIES     = 8,
  parameter int unsigned ADDR_BYTES  = 6,
  parameter int unsigned STRIDE_LOG2 = 4,
  localparam int unsigned AW = $clog2(ENTRIES) + STRIDE_LOG2,
  localparam int unsigned DW = ADDR_BYTES * 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          rom_rd_o,
  input logic [AW-1:0] rom_addr_o,
  input logic [DW-1:0] station_addr_o,
  input logic          done_o,
  input logic          valid_o
);
  a_r1_addr_on_stride: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd_o |-> (rom_addr_o[STRIDE_LOG2-1:0] == '0));

  a_r1_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd_o && !start_i |=> !rom_rd_o);

  a_r6_idle_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !rom_rd_o);

  a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> done_o);

  a_r6_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> done_o);

  a_r7_addr_moves_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(station_addr_o) |-> $rose(done_o));

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o && !valid_o);
endmodule

bind station_addr_loader salp_checker #(
  .ENTRIES    (ENTRIES),
  .ADDR_BYTES (ADDR_BYTES),
  .STRIDE_LOG2(STRIDE_LOG2)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .rom_rd_o      (rom_rd_o),
  .rom_addr_o    (rom_addr_o),
  .station_addr_o(station_addr_o),
  .done_o        (done_o),
  .valid_o       (valid_o)
);

// File: tb/test_station_addr_loader.sv
`timescale 1ns/1ps
module test_station_addr_loader;
  localparam int RD_LAT = 3;
  localparam int RUN    = 8 * (RD_LAT + 1);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        rom_rd_o;
  logic [6:0]  rom_addr_o;
  logic [7:0]  rom_data_i;
  logic [47:0] station_addr_o;
  logic        done_o;
  logic        valid_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  station_addr_loader #(.RD_LAT(RD_LAT)) i_station_addr_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .rom_rd_o(rom_rd_o), .rom_addr_o(rom_addr_o), .rom_data_i(rom_data_i),
    .station_addr_o(station_addr_o), .done_o(done_o), .valid_o(valid_o)
  );

  // PROM model: fixed latency, noise outside the data cycle
  logic [7:0] rom [8];
  logic       pv   [RD_LAT];
  logic [6:0] pa   [RD_LAT];
  logic [7:0] noise = 8'h5A;

  always @(posedge clk) begin
    noise <= {noise[6:0], noise[7] ^ noise[5] ^ noise[4] ^ noise[3]};
    pv[0] <= rom_rd_o;
    pa[0] <= rom_addr_o;
    for (int k = 1; k < RD_LAT; k++) begin
      pv[k] <= pv[k-1];
      pa[k] <= pa[k-1];
    end
  end
  assign rom_data_i = (pv[RD_LAT-1] === 1'b1) ? rom[pa[RD_LAT-1][6:4]] : noise;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = b[i];
    return r;
  endfunction

  function automatic logic [47:0] exp_addr();
    logic [47:0] a;
    for (int j = 0; j < 6; j++) a[47-8*j -: 8] = rev8(rom[j]);
    return a;
  endfunction

  function automatic bit exp_valid();
    logic [7:0] x = 8'h00;
    for (int j = 0; j < 8; j++) x ^= rev8(rom[j]);
    return (x == 8'hFF);
  endfunction

  // strobe monitor: order, stride and spacing (R1), none while done (R6)
  int cyc = 0;
  int last_cyc = 0;
  int last_idx = -1;
  always @(negedge clk) begin
    cyc++;
    if (rst_n && rom_rd_o) begin
      check(rom_addr_o[3:0] == 4'd0, "R1 stride", rom_addr_o, {rom_addr_o[6:4], 4'd0});
      if (rom_addr_o[6:4] != 3'd0) begin
        check(int'(rom_addr_o[6:4]) == last_idx + 1, "R1 order", rom_addr_o[6:4], last_idx + 1);
        check(cyc - last_cyc == RD_LAT + 1, "R1 spacing", cyc - last_cyc, RD_LAT + 1);
      end
      check(!done_o, "R6 no read while done", rom_rd_o, 0);
      last_idx = int'(rom_addr_o[6:4]);
      last_cyc = cyc;
    end
  end

  task automatic fill_random(input bit force_ok);
    logic [7:0] x = 8'h00;
    for (int j = 0; j < 8; j++) rom[j] = 8'($urandom);
    if (force_ok) begin
      for (int j = 0; j < 7; j++) x ^= rev8(rom[j]);
      rom[7] = rev8(x ^ 8'hFF);
    end
  endtask

  // waits for done, checking the held address; returns cycles counted
  task automatic wait_done(input logic [47:0] old_addr, output int n);
    n = 0;
    while (!done_o && n < 1000) begin
      check(station_addr_o == old_addr, "R7 hold during run", station_addr_o, old_addr);
      @(negedge clk);
      n++;
    end
  endtask

  task automatic check_result(input string tag);
    check(station_addr_o == exp_addr(), {"R4 R3 address ", tag}, station_addr_o, exp_addr());
    check(valid_o == exp_valid(), {"R5 check ", tag}, valid_o, exp_valid());
  endtask

  task automatic restart_run(input string tag);
    logic [47:0] old_addr;
    int n;
    old_addr = station_addr_o;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(!done_o && !valid_o, "R8 start clears flags", {done_o, valid_o}, 0);
    wait_done(old_addr, n);
    check(n == RUN, {"R6 done timing ", tag}, n, RUN);
    check_result(tag);
    repeat (4) @(negedge clk);
    check(done_o, "R6 done holds", done_o, 1);
    check(valid_o == exp_valid(), "R6 valid holds", valid_o, exp_valid());
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!done_o && !valid_o && station_addr_o == 48'd0, "R9 reset state",
          {done_o, valid_o, station_addr_o}, 0);
    @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    int n;
    logic [47:0] old_addr;
    void'($urandom(32'd20240611));
    for (int j = 0; j < 8; j++) rom[j] = 8'h00;
    rom[0] = 8'h01;  // reverses to 0x80
    rom[6] = 8'hFE;  // reverses to 0x7F
    // fold: 80 ^ 7F = FF -> valid
    do_reset();
    n = 0;
    while (!done_o && n < 1000) begin
      check(station_addr_o == 48'd0, "R7 hold after reset", station_addr_o, 0);
      @(negedge clk);
      n++;
    end
    check(n == RUN + 1, "R9 first run timing", n, RUN + 1);
    check(station_addr_o == 48'h8000_0000_0000, "R3 bit reversal", station_addr_o, 48'h8000_0000_0000);
    check(valid_o == 1'b1, "R5 directed good", valid_o, 1);

    // all ones: fold of eight FF is 00 -> invalid, address still loaded (R7)
    for (int j = 0; j < 8; j++) rom[j] = 8'hFF;
    restart_run("all ones");
    check(valid_o == 1'b0, "R5 all ones invalid", valid_o, 0);

    // entries 6/7 change only the check (R5)
    for (int j = 0; j < 8; j++) rom[j] = 8'(8'h11 * j);
    restart_run("pattern a");
    old_addr = station_addr_o;
    rom[6] = 8'h3C; rom[7] = 8'hC5;
    restart_run("pattern b");
    check(station_addr_o == old_addr, "R5 tail bytes ignored for address", station_addr_o, old_addr);

    // restart collides with capture of entry 7 (R8)
    fill_random(1'b1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    old_addr = station_addr_o;
    repeat (8 * RD_LAT + 7) @(negedge clk);
    start_i = 1'b1;
    fill_random(1'b0);
    @(negedge clk);
    start_i = 1'b0;
    check(!done_o, "R8 restart beats final capture", done_o, 0);
    check(station_addr_o == old_addr, "R8 address kept on collision", station_addr_o, old_addr);
    wait_done(old_addr, n);
    check(n == RUN, "R8 run after collision", n, RUN);
    check_result("after collision");

    // mid-run restart with new contents (R8)
    fill_random(1'b1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (11) @(negedge clk);
    fill_random(1'b1);
    restart_run("mid-run restart");

    // reset in mid run (R9)
    fill_random(1'b0);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (9) @(negedge clk);
    fill_random(1'b1);
    do_reset();
    wait_done(48'd0, n);
    check(n == RUN + 1, "R9 run after reset", n, RUN + 1);
    check_result("after reset");

    // random images, noise on data bus between reads (R2)
    for (int t = 0; t < 24; t++) begin
      fill_random(t[0]);
      restart_run("random");
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule